// File: doc/BRIEF.md
# Manual DRAM Maintenance Command Requester

This block sits in the register space of a DRAM controller. Software uses it to start three maintenance operations by hand: a control-update request toward the PHY, a short ZQ calibration, and a refresh to rank 0. A single command register is written over a simple register port. Each bit written as 1 becomes a pending request. The request is offered to the command scheduler on its own valid/accept pair and stays pending until the scheduler accepts it.

Each manual request is honoured only while the matching automatic mechanism is switched off by its configuration input. The short ZQ request also follows the controller's operating mode. In self-refresh it is held back. In deep power-down or maximum power saving it is dropped without being issued, and its busy flag falls anyway. A read of the command register returns the live pending state, so the bits appear to clear by themselves once their request has been taken.

Top module: `maint_cmd_req`

## Requirements
- R1: After reset, no request is pending. All three valid outputs, both busy outputs and the register readback are 0.
- R2: A write to the command address (default 0x30C) with bit 5 set, while `auto_ctrlupd_off` is 1, raises `cu_valid` on the next cycle. `cu_valid` stays high until the cycle in which `cu_accept` is also high, and it is low on the cycle after that.
- R3: A write with bit 4 set, while `auto_zq_off` is 1, makes a short ZQ request pending. `zq_busy` is high exactly while it is pending, and `zq_valid` is high only while `zq_busy` is high.
- R4: A write with bit 0 set, while `auto_refresh_off` is 1, raises `rf_busy` and `rf_valid` on the next cycle. Both clear on the cycle after `rf_valid` and `rf_accept` are high together. `rf_rank_idx` is always 0.
- R5: A command bit written while its automatic mechanism is enabled (its `*_off` input is 0) is ignored and leaves nothing pending.
- R6: While `op_mode` is 1 (self-refresh), a pending ZQ request keeps `zq_busy` high and `zq_valid` low. Once `op_mode` leaves 1, `zq_valid` rises in the same cycle.
- R7: While `op_mode` is 2 (deep power-down) or 3 (maximum power saving), `zq_valid` is low. A pending ZQ request is discarded, so `zq_busy` is low on the following cycle.
- R8: A write of 1 to a bit whose request is already pending is absorbed. A single acceptance clears the request, and no second request follows.
- R9: A read at the command address returns the pending control-update, ZQ and refresh requests in bits 5, 4 and 0, with every other bit 0. A read at any other address returns 0.
- R10: Writes to any address other than the command address create no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 12 | Register address for both read and write |
| reg_wr_en | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational readback for `reg_addr` |
| auto_ctrlupd_off | input | 1 | 1 when automatic control update is disabled |
| auto_zq_off | input | 1 | 1 when automatic ZQ calibration is disabled |
| auto_refresh_off | input | 1 | 1 when automatic refresh is disabled |
| op_mode | input | 3 | Operating mode: 0 normal, 1 self-refresh, 2 deep power-down, 3 maximum power saving, 4 init |
| cu_valid | output | 1 | Control-update request offered |
| cu_accept | input | 1 | Scheduler takes the control-update request |
| zq_valid | output | 1 | Short ZQ request offered |
| zq_accept | input | 1 | Scheduler takes the ZQ request |
| rf_valid | output | 1 | Rank-0 refresh request offered |
| rf_accept | input | 1 | Scheduler takes the refresh request |
| rf_rank_idx | output | 2 | Logical rank targeted by the refresh, always 0 |
| zq_busy | output | 1 | ZQ request pending |
| rf_busy | output | 1 | Refresh request pending |

## Verification
A write sampled at one rising edge shows up on the valid, busy and readback outputs after that edge, so it is seen one cycle after the write is presented. An acceptance removes the request in the same way, after the edge that samples it. The self-refresh hold and the low-power gating act on `zq_valid` within the same cycle as the mode change, while a discard clears `zq_busy` one cycle later. The bench drives inputs on the falling edge and compares every output with its reference model shortly after each rising edge. Its directed checks sample on the falling edge that follows the edge that took the stimulus.

// File: rtl/maint_cmd_pkg.sv
package maint_cmd_pkg;

    typedef enum logic [2:0] {
        MODE_NORMAL   = 3'd0,
        MODE_SELF_REF = 3'd1,
        MODE_DEEP_PD  = 3'd2,
        MODE_MAX_SAVE = 3'd3,
        MODE_INIT     = 3'd4
    } op_mode_e;

    // slot index of each command
    localparam int NUM_CMD = 3;
    localparam int CMD_RF  = 0;
    localparam int CMD_ZQ  = 1;
    localparam int CMD_CU  = 2;

    // bit positions inside the command register
    localparam int BIT_RF = 0;
    localparam int BIT_ZQ = 4;
    localparam int BIT_CU = 5;

    typedef struct packed {
        logic pend;
    } slot_state_t;

endpackage

// File: rtl/maint_req_slot.sv
module maint_req_slot (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic fire_i,
    input  logic drop_i,
    output logic pend_o
);
    import maint_cmd_pkg::*;

    slot_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.pend) begin
            // an extra set while pending merges into the live request
            if (fire_i || drop_i) st_d.pend = 1'b0;
        end else if (set_i) begin
            st_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;

endmodule

// File: rtl/maint_cmd_decode.sv
module maint_cmd_decode #(
    parameter int                ADDR_W   = 12,
    parameter int                DATA_W   = 32,
    parameter logic [ADDR_W-1:0] CMD_ADDR = 12'h30C
) (
    input  logic                                reg_wr_en,
    input  logic [ADDR_W-1:0]                   reg_addr,
    input  logic [DATA_W-1:0]                   reg_wdata,
    input  logic [maint_cmd_pkg::NUM_CMD-1:0]   auto_off,
    input  logic [maint_cmd_pkg::NUM_CMD-1:0]   pend,
    output logic [maint_cmd_pkg::NUM_CMD-1:0]   set_req,
    output logic [DATA_W-1:0]                   reg_rdata
);
    import maint_cmd_pkg::*;

    logic hit;
    logic [NUM_CMD-1:0] wbits;

    assign hit = (reg_addr == CMD_ADDR);

    always_comb begin
        wbits         = '0;
        wbits[CMD_RF] = reg_wdata[BIT_RF];
        wbits[CMD_ZQ] = reg_wdata[BIT_ZQ];
        wbits[CMD_CU] = reg_wdata[BIT_CU];
        set_req       = (reg_wr_en && hit) ? (wbits & auto_off) : '0;
    end

    always_comb begin
        reg_rdata = '0;
        if (hit) begin
            reg_rdata[BIT_RF] = pend[CMD_RF];
            reg_rdata[BIT_ZQ] = pend[CMD_ZQ];
            reg_rdata[BIT_CU] = pend[CMD_CU];
        end
    end

endmodule

// File: rtl/maint_zq_gate.sv
module maint_zq_gate (
    input  logic       pend,
    input  logic [2:0] op_mode,
    output logic       valid,
    output logic       drop
);
    import maint_cmd_pkg::*;

    op_mode_e mode;
    logic     hold, lowpwr;

    always_comb begin
        mode   = op_mode_e'(op_mode);
        hold   = (mode == MODE_SELF_REF);
        lowpwr = (mode == MODE_DEEP_PD) || (mode == MODE_MAX_SAVE);
        drop   = pend && lowpwr;
        valid  = pend && !hold && !lowpwr;
    end

endmodule

// File: rtl/maint_cmd_req.sv
module maint_cmd_req #(
    parameter int                ADDR_W   = 12,
    parameter int                DATA_W   = 32,
    parameter int                RANK_W   = 2,
    parameter logic [ADDR_W-1:0] CMD_ADDR = 12'h30C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr_en,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              auto_ctrlupd_off,
    input  logic              auto_zq_off,
    input  logic              auto_refresh_off,
    input  logic [2:0]        op_mode,
    output logic              cu_valid,
    input  logic              cu_accept,
    output logic              zq_valid,
    input  logic              zq_accept,
    output logic              rf_valid,
    input  logic              rf_accept,
    output logic [RANK_W-1:0] rf_rank_idx,
    output logic              zq_busy,
    output logic              rf_busy
);
    import maint_cmd_pkg::*;

    logic [NUM_CMD-1:0] auto_off, set_req, pend, valid, accept, fire, drop;
    logic               zq_gate_valid, zq_gate_drop;

    always_comb begin
        auto_off         = '0;
        auto_off[CMD_RF] = auto_refresh_off;
        auto_off[CMD_ZQ] = auto_zq_off;
        auto_off[CMD_CU] = auto_ctrlupd_off;
        accept           = '0;
        accept[CMD_RF]   = rf_accept;
        accept[CMD_ZQ]   = zq_accept;
        accept[CMD_CU]   = cu_accept;
    end

    maint_cmd_decode #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .CMD_ADDR(CMD_ADDR)
    ) u_dec (
        .reg_wr_en(reg_wr_en),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .auto_off (auto_off),
        .pend     (pend),
        .set_req  (set_req),
        .reg_rdata(reg_rdata)
    );

    maint_zq_gate u_zq_gate (
        .pend   (pend[CMD_ZQ]),
        .op_mode(op_mode),
        .valid  (zq_gate_valid),
        .drop   (zq_gate_drop)
    );

    for (genvar i = 0; i < NUM_CMD; i++) begin : g_slot
        if (i == CMD_ZQ) begin : g_gated
            assign valid[i] = zq_gate_valid;
            assign drop[i]  = zq_gate_drop;
        end else begin : g_plain
            assign valid[i] = pend[i];
            assign drop[i]  = 1'b0;
        end
        assign fire[i] = valid[i] && accept[i];

        maint_req_slot u_slot (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (set_req[i]),
            .fire_i(fire[i]),
            .drop_i(drop[i]),
            .pend_o(pend[i])
        );
    end

    assign cu_valid    = valid[CMD_CU];
    assign zq_valid    = valid[CMD_ZQ];
    assign rf_valid    = valid[CMD_RF];
    assign zq_busy     = pend[CMD_ZQ];
    assign rf_busy     = pend[CMD_RF];
    assign rf_rank_idx = '0;

endmodule

// File: rtl/maint_cmd_req_chk.sv
module maint_cmd_req_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       auto_zq_off,
    input logic [2:0] op_mode,
    input logic       cu_valid,
    input logic       cu_accept,
    input logic       zq_valid,
    input logic       rf_valid,
    input logic       rf_accept,
    input logic       zq_busy,
    input logic       rf_busy
);

    a_r2_cu_holds: assert property (@(posedge clk) disable iff (!rst_n)
        cu_valid && !cu_accept |=> cu_valid);

    a_r2_cu_clears: assert property (@(posedge clk) disable iff (!rst_n)
        cu_valid && cu_accept |=> !cu_valid);

    a_r3_zq_valid_busy: assert property (@(posedge clk) disable iff (!rst_n)
        zq_valid |-> zq_busy);

    a_r4_rf_clears: assert property (@(posedge clk) disable iff (!rst_n)
        rf_valid && rf_accept |=> !rf_busy);

    a_r5_zq_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_zq_off && !zq_busy |=> !zq_busy);

    a_r6_sr_holds_zq: assert property (@(posedge clk) disable iff (!rst_n)
        op_mode == 3'd1 |-> !zq_valid);

    a_r7_lowpwr_no_zq: assert property (@(posedge clk) disable iff (!rst_n)
        (op_mode == 3'd2 || op_mode == 3'd3) |-> !zq_valid);

    a_r7_lowpwr_drops: assert property (@(posedge clk) disable iff (!rst_n)
        zq_busy && (op_mode == 3'd2 || op_mode == 3'd3) |=> !zq_busy);

endmodule

bind maint_cmd_req maint_cmd_req_chk u_chk (.*);

// File: tb/tb_maint_cmd_req.sv
`timescale 1ns/1ps
module tb_maint_cmd_req;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] reg_addr = 12'h30C;
    logic        reg_wr_en = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        auto_ctrlupd_off = 1'b1, auto_zq_off = 1'b1, auto_refresh_off = 1'b1;
    logic [2:0]  op_mode = 3'd0;
    logic        cu_valid, zq_valid, rf_valid, zq_busy, rf_busy;
    logic        cu_accept = 1'b0, zq_accept = 1'b0, rf_accept = 1'b0;
    logic [1:0]  rf_rank_idx;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #5 clk = ~clk;

    maint_cmd_req dut (.*);

    // behavioural reference: one integer per outstanding request
    int m_cu = 0, m_zq = 0, m_rf = 0;

    function automatic int m_zq_ok();
        return (m_zq != 0) && op_mode != 3'd1 && op_mode != 3'd2 && op_mode != 3'd3;
    endfunction

    always @(posedge clk) begin
        int hit, n_cu, n_zq, n_rf;
        if (!rst_n) begin
            m_cu = 0; m_zq = 0; m_rf = 0;
        end else begin
            hit  = reg_wr_en && reg_addr == 12'h30C;
            n_cu = m_cu; n_zq = m_zq; n_rf = m_rf;
            if (m_cu != 0) begin if (cu_accept) n_cu = 0; end
            else if (hit && reg_wdata[5] && auto_ctrlupd_off) n_cu = 1;
            if (m_zq != 0) begin
                if (op_mode == 3'd2 || op_mode == 3'd3) n_zq = 0;
                else if (m_zq_ok() && zq_accept) n_zq = 0;
            end else if (hit && reg_wdata[4] && auto_zq_off) n_zq = 1;
            if (m_rf != 0) begin if (rf_accept) n_rf = 0; end
            else if (hit && reg_wdata[0] && auto_refresh_off) n_rf = 1;
            m_cu = n_cu; m_zq = n_zq; m_rf = n_rf;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // compare against the model shortly after every rising edge
    always begin
        @(posedge clk);
        #2;
        if (rst_n && !done) begin
            chk("R2 cu_valid", {31'b0, cu_valid}, (m_cu != 0));
            chk("R6 zq_valid", {31'b0, zq_valid}, m_zq_ok());
            chk("R3 zq_busy",  {31'b0, zq_busy},  (m_zq != 0));
            chk("R4 rf_busy",  {31'b0, rf_busy},  (m_rf != 0));
            chk("R4 rf_valid", {31'b0, rf_valid}, (m_rf != 0));
            chk("R9 readback", reg_rdata,
                (reg_addr == 12'h30C) ? ((m_cu << 5) | (m_zq << 4) | m_rf) : 32'h0);
        end
    end

    task automatic step(); @(negedge clk); endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
        step();
        reg_wr_en = 1'b0; reg_addr = 12'h30C;
    endtask

    task automatic finish_run();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) step();
        chk("R1 rdata", reg_rdata, 32'h0);
        chk("R1 valids", {29'b0, cu_valid, zq_valid, rf_valid}, 32'h0);
        rst_n = 1'b1;
        step();
        chk("R1 busy", {30'b0, zq_busy, rf_busy}, 32'h0);

        // all three commands at once
        wr(12'h30C, 32'h31);
        chk("R9 pending bits", reg_rdata, 32'h31);
        chk("R2 cu raised", {31'b0, cu_valid}, 32'h1);
        chk("R3 zq busy", {31'b0, zq_busy}, 32'h1);
        chk("R4 rf busy", {31'b0, rf_busy}, 32'h1);
        chk("R4 rank", {30'b0, rf_rank_idx}, 32'h0);
        step();
        chk("R2 cu held", {31'b0, cu_valid}, 32'h1);

        // second write absorbed while accepting
        cu_accept = 1'b1;
        wr(12'h30C, 32'h20);
        cu_accept = 1'b0;
        chk("R8 cu cleared once", {31'b0, cu_valid}, 32'h0);
        step(); step();
        chk("R8 no second cu", {31'b0, cu_valid}, 32'h0);
        zq_accept = 1'b1; rf_accept = 1'b1;
        step();
        zq_accept = 1'b0; rf_accept = 1'b0;
        chk("R3 zq done", {31'b0, zq_busy}, 32'h0);
        chk("R4 rf done", {31'b0, rf_busy}, 32'h0);

        // automatic mechanisms enabled
        auto_zq_off = 1'b0; auto_ctrlupd_off = 1'b0; auto_refresh_off = 1'b0;
        wr(12'h30C, 32'h31);
        chk("R5 ignored", reg_rdata, 32'h0);
        auto_zq_off = 1'b1; auto_ctrlupd_off = 1'b1; auto_refresh_off = 1'b1;

        // wrong address, other bits, other read address
        wr(12'h308, 32'h31);
        chk("R10 other addr", reg_rdata, 32'h0);
        wr(12'h30C, 32'hFFFF_FFFF);
        chk("R9 only three bits", reg_rdata, 32'h31);
        reg_addr = 12'h300;
        #1 chk("R9 other read", reg_rdata, 32'h0);
        reg_addr = 12'h30C;
        cu_accept = 1'b1; zq_accept = 1'b1; rf_accept = 1'b1;
        step();
        cu_accept = 1'b0; zq_accept = 1'b0; rf_accept = 1'b0;

        // self-refresh hold
        op_mode = 3'd1;
        wr(12'h30C, 32'h10);
        step(); step();
        chk("R6 held busy", {31'b0, zq_busy}, 32'h1);
        chk("R6 held valid", {31'b0, zq_valid}, 32'h0);
        op_mode = 3'd0;
        #1 chk("R6 released", {31'b0, zq_valid}, 32'h1);
        zq_accept = 1'b1; step(); zq_accept = 1'b0;

        // discard in deep power-down and max power saving
        op_mode = 3'd2;
        wr(12'h30C, 32'h10);
        step();
        chk("R7 dpd drop", {30'b0, zq_busy, zq_valid}, 32'h0);
        op_mode = 3'd0;
        wr(12'h30C, 32'h10);
        op_mode = 3'd3;
        #1 chk("R7 mps no valid", {31'b0, zq_valid}, 32'h0);
        step();
        chk("R7 mps drop", {31'b0, zq_busy}, 32'h0);
        op_mode = 3'd0;

        // random traffic against the model
        for (int i = 0; i < 400; i++) begin
            reg_wr_en        = ($urandom_range(0, 3) == 0);
            reg_addr         = ($urandom_range(0, 7) == 0) ? 12'h308 : 12'h30C;
            reg_wdata        = $urandom;
            auto_ctrlupd_off = ($urandom_range(0, 5) != 0);
            auto_zq_off      = ($urandom_range(0, 5) != 0);
            auto_refresh_off = ($urandom_range(0, 5) != 0);
            op_mode          = ($urandom_range(0, 3) == 0) ? 3'($urandom_range(0, 4)) : 3'd0;
            cu_accept        = $urandom_range(0, 1);
            zq_accept        = $urandom_range(0, 1);
            rf_accept        = $urandom_range(0, 1);
            step();
        end
        reg_wr_en = 1'b0;
        step(); step();
        finish_run();
    end

endmodule